// File: doc/BRIEF.md
# Fractional-N Modulus Accumulator

This block generates the modulus-select signal for a dual-modulus (N/N+1) divider so that a synthesizer loop divides by a fractional average ratio. It runs on the divided oscillator clock, which is the divider's own output, and not on the reference. On every divided-clock edge it adds a channel word to an 8-bit phase register. The register wraps at a programmable modulus. Each wrap asks the divider to divide by N+1 for the whole of the next divided period.

Take one full fractional cycle of M divided periods. The wrap count over that cycle equals the effective channel word K, so the average division ratio is N + K/M. With a reference near 27.8 MHz, N = 32 and M = 139, one step of K moves the output by about 200 kHz, starting near 890 MHz. The modulus need not be a power of two, so the wrap uses an explicit compare and subtract on a sum one bit wider than the register. A modulus input of zero selects a built-in default of 139.

Top module: `frac_mod_acc`

## Requirements
- R1: While `rst_n` is low at a rising `div_clk` edge, the edge leaves `phase` at 0 and `mod_sel` at 0.
- R2: At each active edge, with phase below M, let S = phase + K. If S is at least M, `phase` becomes S − M and `mod_sel` is 1 for the following period. Otherwise `phase` becomes S and `mod_sel` is 0.
- R3: Over any M consecutive active edges with fixed inputs and a phase below M, `mod_sel` is high in exactly K of the periods, and `phase` ends at its starting value.
- R4: A channel word at or above M is clamped to M − 1. `k_clip` is high, combinationally, exactly when `chan_k` ≥ M.
- R5: `modulus` = 0 selects the default modulus 139. Any nonzero value is used as M directly, 1 to 255.
- R6: If `phase` is at or above M at an active edge, because the modulus was lowered, the edge sets `phase` to 0 and `mod_sel` to 0.
- R7: `mod_sel` and `phase` change only at a rising `div_clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| div_clk | input | 1 | Divided oscillator clock (output of the N/N+1 divider) |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_k | input | 8 | Fractional channel word K |
| modulus | input | 8 | Wrap modulus M; 0 selects the default of 139 |
| mod_sel | output | 1 | Registered modulus control: 1 requests divide by N+1 |
| phase | output | 8 | Current accumulator phase |
| k_clip | output | 1 | High when `chan_k` is at or above the effective modulus |

## Verification
The hardest state to reach from the ports is a phase that is already at or above the modulus. That only happens when the modulus is lowered while the phase is high. The stimulus first steps the phase to a known large value under M = 139, then drops the modulus below that value for exactly one edge. Separately, every channel word from 0 to 138 runs for a full 139-period window, with the wrap count and the returning phase computed arithmetically. Other moduli, clamped words and the zero-means-default setting are covered the same way.

// File: rtl/fm_pkg.sv
// Package: shared types for the fractional modulus accumulator.
// Assumes: nothing; holds the step classification used between stages.
package fm_pkg;
    typedef enum logic [1:0] {
        STEP_ACCUM  = 2'd0,  // sum below modulus, stored as is
        STEP_CARRY  = 2'd1,  // sum reached modulus, wrap and request N+1
        STEP_RESYNC = 2'd2   // phase already out of range, restart at zero
    } step_kind_e;
endpackage

// File: rtl/fm_k_limit.sv
// Module: fm_k_limit
// Resolves the effective modulus (0 selects DEF_MOD) and clamps the channel
// word to one below it. Assumes 1 <= DEF_MOD < 2**W.
module fm_k_limit #(
    parameter int W       = 8,
    parameter int DEF_MOD = 139
) (
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] k_in,
    output logic [W-1:0] mod_eff,
    output logic [W-1:0] k_eff,
    output logic         k_clip
);
    localparam logic [W-1:0] DefModW = W'(DEF_MOD);

    // Purpose: pick modulus, detect and clamp an out-of-range word.
    always_comb begin
        mod_eff = (modulus == '0) ? DefModW : modulus;
        k_clip  = (k_in >= mod_eff);
        k_eff   = k_clip ? (mod_eff - W'(1)) : k_in;
    end

    // Purpose: the clamped word always lies below the modulus.
    always_comb begin
        AST_K_BELOW_MOD: assert (k_eff < mod_eff) else $error("clamp out of range"); // R4
    end
endmodule

// File: rtl/fm_wrap_step.sv
// Module: fm_wrap_step
// Combinational next-state for one divided period: add, compare, subtract.
// Assumes k_eff < mod_eff; uses a W+1 bit sum so no wrap precedes the compare.
module fm_wrap_step #(
    parameter int W = 8
) (
    input  logic [W-1:0]        phase_q,
    input  logic [W-1:0]        k_eff,
    input  logic [W-1:0]        mod_eff,
    output logic [W-1:0]        phase_d,
    output logic                carry_d,
    output fm_pkg::step_kind_e  kind
);
    import fm_pkg::*;

    logic [W:0] sum_ext;
    logic [W:0] mod_ext;

    // Purpose: classify the step and form the next phase.
    always_comb begin
        sum_ext = {1'b0, phase_q} + {1'b0, k_eff};
        mod_ext = {1'b0, mod_eff};
        if (phase_q >= mod_eff) begin
            kind    = STEP_RESYNC;
            phase_d = '0;
            carry_d = 1'b0;
        end else if (sum_ext >= mod_ext) begin
            kind    = STEP_CARRY;
            phase_d = W'(sum_ext - mod_ext);
            carry_d = 1'b1;
        end else begin
            kind    = STEP_ACCUM;
            phase_d = W'(sum_ext);
            carry_d = 1'b0;
        end
    end
endmodule

// File: rtl/fm_phase_reg.sv
// Module: fm_phase_reg
// Holds the phase and the registered modulus-control bit for one full
// divided period. Synchronous active-low reset clears both.
module fm_phase_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] phase_d,
    input  logic         carry_d,
    output logic [W-1:0] phase_q,
    output logic         mc_q
);
    // Purpose: update state once per divided-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            mc_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            mc_q    <= carry_d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (phase_q == '0 && !mc_q)) else $error("reset"); // R1
endmodule

// File: rtl/frac_mod_acc.sv
// Module: frac_mod_acc (top)
// Fractional-N modulus accumulator clocked by the divided oscillator clock.
// Assumes the divider samples mod_sel once per divided period.
module frac_mod_acc #(
    parameter int ACC_W   = 8,
    parameter int DEF_MOD = 139
) (
    input  logic             div_clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] chan_k,
    input  logic [ACC_W-1:0] modulus,
    output logic             mod_sel,
    output logic [ACC_W-1:0] phase,
    output logic             k_clip
);
    import fm_pkg::*;

    logic [ACC_W-1:0] mod_eff;
    logic [ACC_W-1:0] k_eff;
    logic [ACC_W-1:0] phase_d;
    logic             carry_d;
    step_kind_e       kind;

    fm_k_limit #(.W(ACC_W), .DEF_MOD(DEF_MOD)) u_limit (
        .modulus (modulus),
        .k_in    (chan_k),
        .mod_eff (mod_eff),
        .k_eff   (k_eff),
        .k_clip  (k_clip)
    );

    fm_wrap_step #(.W(ACC_W)) u_step (
        .phase_q (phase),
        .k_eff   (k_eff),
        .mod_eff (mod_eff),
        .phase_d (phase_d),
        .carry_d (carry_d),
        .kind    (kind)
    );

    fm_phase_reg #(.W(ACC_W)) u_reg (
        .clk     (div_clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .carry_d (carry_d),
        .phase_q (phase),
        .mc_q    (mod_sel)
    );

    // Step kind and carry must agree.
    always_comb begin
        AST_KIND_MATCH: assert ((kind == STEP_CARRY) == carry_d) else $error("kind"); // R2
    end

    AST_CARRY_STEP: assert property (@(posedge div_clk) disable iff (!rst_n)
        ($past(rst_n) && mod_sel) |->
        ({1'b0, phase} + {1'b0, $past(mod_eff)} == {1'b0, $past(phase)} + {1'b0, $past(k_eff)}))
        else $error("carry step"); // R2

    AST_HOLD_STEP: assert property (@(posedge div_clk) disable iff (!rst_n)
        ($past(rst_n) && !mod_sel && ($past(phase) < $past(mod_eff))) |->
        ({1'b0, phase} == {1'b0, $past(phase)} + {1'b0, $past(k_eff)}))
        else $error("hold step"); // R2

    AST_RESYNC: assert property (@(posedge div_clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(phase) >= $past(mod_eff))) |-> (phase == '0 && !mod_sel))
        else $error("resync"); // R6

    AST_PHASE_BELOW_MOD: assert property (@(posedge div_clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase < $past(mod_eff))) else $error("phase bound"); // R3
endmodule

// File: tb/frac_mod_acc_test.sv
module frac_mod_acc_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEFM = 139;

    logic       div_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] chan_k  = '0;
    logic [7:0] modulus = '0;
    logic       mod_sel;
    logic [7:0] phase;
    logic       k_clip;

    int n_checks = 0;
    int n_errors = 0;
    int m_phase  = 0;
    int m_mc     = 0;

    frac_mod_acc uut (
        .div_clk (div_clk),
        .rst_n   (rst_n),
        .chan_k  (chan_k),
        .modulus (modulus),
        .mod_sel (mod_sel),
        .phase   (phase),
        .k_clip  (k_clip)
    );

    always #(CLK_PERIOD/2) div_clk = ~div_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_mod(input int m);
        return (m == 0) ? DEFM : m;
    endfunction

    function automatic int eff_k(input int k, input int m);
        return (k >= m) ? m - 1 : k;
    endfunction

    // One divided period: update model, clock, sample at the falling edge.
    task automatic step(input string req);
        int me = eff_mod(int'(modulus));
        int ke = eff_k(int'(chan_k), me);
        if (!rst_n) begin
            m_phase = 0; m_mc = 0;
        end else if (m_phase >= me) begin
            m_phase = 0; m_mc = 0;
        end else if (m_phase + ke >= me) begin
            m_phase = m_phase + ke - me; m_mc = 1;
        end else begin
            m_phase = m_phase + ke; m_mc = 0;
        end
        @(posedge div_clk);
        #1;
        check(int'(phase) == m_phase, {req, " phase after edge"}, int'(phase), m_phase);
        check(int'(mod_sel) == m_mc, {req, " mod_sel after edge"}, int'(mod_sel), m_mc);
        @(negedge div_clk);
        check(int'(mod_sel) == m_mc, "R7 mod_sel held mid-period", int'(mod_sel), m_mc);
    endtask

    // Full fractional window: count wraps and compare the ending phase.
    task automatic window(input int k, input int m);
        int me = eff_mod(m);
        int ke = eff_k(k, me);
        int start;
        int cnt = 0;
        chan_k  = 8'(k);
        modulus = 8'(m);
        #1;
        check(int'(k_clip) == ((k >= me) ? 1 : 0), "R4 k_clip", int'(k_clip), (k >= me) ? 1 : 0);
        start = int'(phase);
        for (int i = 0; i < me; i++) begin
            step("R2");
            if (mod_sel) cnt++;
        end
        check(cnt == ke, "R3 wrap count", cnt, ke);
        check(int'(phase) == start, "R3 phase returns", int'(phase), start);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge div_clk);
        rst_n = 1'b0;
        step("R1");
        check(phase == 8'd0 && mod_sel == 1'b0, "R1 reset state", int'(phase), 0);
        rst_n = 1'b1;
        @(negedge div_clk);

        // R3/R2: every word under the default modulus 139.
        for (int k = 0; k < DEFM; k++) window(k, 139);
        // R5: zero selects the default modulus.
        window(7, 0);
        window(150, 0);
        // R4: clamping under the default modulus.
        window(200, 139);
        window(139, 139);
        // Other moduli.
        for (int k = 0; k < 17; k++) window(k, 17);
        window(30, 17);
        window(254, 255);
        window(1, 255);
        window(0, 1);
        window(5, 1);

        // R6: lower the modulus below the current phase.
        rst_n = 1'b0; step("R1"); rst_n = 1'b1;
        chan_k = 8'd100; modulus = 8'd139;
        step("R2");
        check(int'(phase) == 100, "R6 setup phase", int'(phase), 100);
        modulus = 8'd60;
        step("R6");
        check(phase == 8'd0 && !mod_sel, "R6 resync to zero", int'(phase), 0);

        // R1: reset mid-run clears a nonzero phase.
        chan_k = 8'd45;
        step("R2");
        rst_n = 1'b0;
        step("R1");
        check(phase == 8'd0 && !mod_sel, "R1 mid-run reset", int'(phase), 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule